// File: doc/BRIEF.md
# Bit-Serial Dual-Basis GF(16) Multiplier

This block multiplies two elements of GF(2^4), where the field is built on the fixed polynomial x^4 + x + 1 and alpha is a root of it. A start pulse captures a constant operand A in polynomial form. The second operand B then streams in one coordinate per clock, highest index first, in a dual (trace-sequence) coordinate form. The product leaves one coordinate per clock in the same dual form, with a valid strobe and a done pulse on the final bit.

Internally the four most recent operand coordinates sit in a short shift register. Once the operand has been fully received, the register turns into a linear feedback shift register that steps the coordinate sequence downward, following the recurrence implied by x^4 + x + 1. Each product bit is a fixed XOR of the window bits that the constant A selects. The first product bit leaves in the same cycle that the last operand bit arrives. This lets a downstream serial XOR accumulator add successive products bit by bit, in the same index order.

Top module: `gf4_dual_serial_mul`

## Requirements
- R1: `a_in` is captured only in a cycle where `start` is high. Changes to `a_in` at any other time do not alter the product in progress.
- R2: The four operand coordinates are sampled on `b_bit` in the four cycles after the `start` cycle, in the order d3, d2, d1, d0. The dual coordinate d_k(X) is the constant coefficient of alpha^(-k)*X. Equivalently, d_k is the XOR of polynomial bits x_0 through x_k.
- R3: `p_valid` is high for exactly four consecutive cycles. The first of these is the cycle in which d0 is on `b_bit`, which is the fourth cycle after `start`.
- R4: During the valid cycles, `p_bit` carries the dual coordinates c3, c2, c1, c0 of A*B, in that order. The value of `a_in` is in polynomial form, with bit i being the coefficient of alpha^i.
- R5: `done` is high for exactly one cycle, and that cycle is the one carrying c0.
- R6: When no operation is running, `p_valid`, `p_bit` and `done` stay low, and `b_bit` has no effect. While the product bits are leaving, `b_bit` is also ignored.
- R7: A `start` during a running operation aborts it. The new operation then follows the timing of R2 to R5, counted from the new `start`.
- R8: While reset is applied and after it is released, `p_valid`, `p_bit` and `done` are low until a `start` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| start | input | 1 | Begins an operation and captures a_in |
| a_in | input | 4 | Constant operand A, polynomial coordinates |
| b_bit | input | 1 | Serial operand coordinate, d3 first |
| p_bit | output | 1 | Serial product coordinate, c3 first |
| p_valid | output | 1 | High while p_bit carries a product coordinate |
| done | output | 1 | High in the cycle carrying the last product coordinate |

## Verification
The bench multiplies all 256 operand pairs. It converts the four emitted coordinates back to polynomial form and compares the result with its own shift-and-reduce product, so a wrong feedback tap or a coefficient paired with the wrong window bit appears as a wrong value for many pairs. It checks that the first valid bit appears in the cycle of the last operand bit. A design that registered the product would be one cycle late, and one that missed the bypass would emit a stale c3 whenever A has its top bit set. Operand bits that are scrambled after loading, and a_in values changed mid-operation, expose a design that keeps sampling either input. An abort two bits into an operation catches a counter or window that is not cleared on restart.

// File: rtl/gf4_dsm_pkg.sv
package gf4_dsm_pkg;

  // Field degree; the field polynomial x^4 + x + 1 is fixed.
  localparam int unsigned FIELD_M = 4;

  // Downward step of the coordinate sequence: d(n-4) = d(n-1) ^ d(n).
  // With the window holding d(n+3)..d(n) in bits [3:0], the new low bit
  // is the XOR of the two highest window bits.
  localparam logic [FIELD_M-1:0] STEP_TAPS = 4'b1100;

  // Inner product over GF(2): coefficient i pairs with window bit M-1-i.
  function automatic logic lin_comb(input logic [FIELD_M-1:0] coef,
                                    input logic [FIELD_M-1:0] view);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < FIELD_M; i++) begin
      acc = acc ^ (coef[i] & view[FIELD_M-1-i]);
    end
    return acc;
  endfunction

  // Next lower coordinate produced by the feedback taps.
  function automatic logic step_bit(input logic [FIELD_M-1:0] win);
    return ^(win & STEP_TAPS);
  endfunction

endpackage

// File: rtl/dsm_seq.sv
module dsm_seq #(
  parameter int unsigned M = gf4_dsm_pkg::FIELD_M
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic run,
  output logic load_ph,
  output logic out_ph,
  output logic last_ph
);
  localparam int unsigned CW = $clog2(2 * M);
  localparam logic [CW-1:0] LAST_C  = CW'(2 * M - 2);
  localparam logic [CW-1:0] LOAD_C  = CW'(M);
  localparam logic [CW-1:0] FIRST_O = CW'(M - 1);

  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST_C) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign run     = busy;
  assign load_ph = busy && (cnt < LOAD_C);
  assign out_ph  = busy && (cnt >= FIRST_O);
  assign last_ph = busy && (cnt == LAST_C);

  // R7: a start always leads to a fresh count from zero
  assert_restart_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run && load_ph && !out_ph));

  // R3: the first output cycle overlaps the last load cycle
  assert_first_out_overlaps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_ph) |-> load_ph);

  // R3: output window is contiguous until its last cycle
  assert_out_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ph && !last_ph && !start) |=> out_ph);

  // R5: the final cycle is a single pulse
  assert_last_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_ph |=> !last_ph);

endmodule

// File: rtl/dsm_window.sv
module dsm_window #(
  parameter int unsigned M = gf4_dsm_pkg::FIELD_M
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift,
  input  logic         load_sel,
  input  logic         ser_in,
  output logic [M-1:0] view
);
  import gf4_dsm_pkg::*;

  logic [M-1:0] win;
  logic         feed;

  // While loading, the serial input enters; afterwards the taps extend
  // the coordinate sequence downward.
  assign feed = load_sel ? ser_in : step_bit(win);
  assign view = {win[M-2:0], feed};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win <= '0;
    end else if (clear) begin
      win <= '0;
    end else if (shift) begin
      win <= view;
    end
  end

  // R4: self-stepping follows alpha^4 = alpha + 1 (d(n-4) = d(n-1) ^ d(n))
  assert_step_recurrence_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load_sel && !clear) |=> (win[0] == ($past(win[3]) ^ $past(win[2]))));

  // R6: the window holds still when no step is requested
  assert_window_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !clear) |=> $stable(win));

endmodule

// File: rtl/dsm_coef.sv
module dsm_coef #(
  parameter int unsigned M = gf4_dsm_pkg::FIELD_M
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [M-1:0] a_in,
  input  logic [M-1:0] view,
  output logic         prod
);
  import gf4_dsm_pkg::*;

  logic [M-1:0] a_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_reg <= '0;
    end else if (load) begin
      a_reg <= a_in;
    end
  end

  // Constant operand selects which window bits are XORed together.
  assign prod = lin_comb(a_reg, view);

  // R1: the constant operand changes only on a load
  assert_coef_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(a_reg));

endmodule

// File: rtl/gf4_dual_serial_mul.sv
module gf4_dual_serial_mul (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] a_in,
  input  logic       b_bit,
  output logic       p_bit,
  output logic       p_valid,
  output logic       done
);
  import gf4_dsm_pkg::*;

  localparam int unsigned M = FIELD_M;

  logic         run;
  logic         load_ph;
  logic         out_ph;
  logic         last_ph;
  logic [M-1:0] view;
  logic         prod;

  dsm_seq #(.M(M)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .run     (run),
    .load_ph (load_ph),
    .out_ph  (out_ph),
    .last_ph (last_ph)
  );

  dsm_window #(.M(M)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .shift    (run),
    .load_sel (load_ph),
    .ser_in   (b_bit),
    .view     (view)
  );

  dsm_coef #(.M(M)) u_coef (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .a_in  (a_in),
    .view  (view),
    .prod  (prod)
  );

  assign p_valid = out_ph;
  assign p_bit   = out_ph & prod;
  assign done    = last_ph;

  // R6: no product bit outside the valid window
  assert_quiet_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !p_valid |-> !p_bit);

  // R5: done only ever marks a valid product bit
  assert_done_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> p_valid);

endmodule

// File: tb/tb_gf4_dual_serial_mul.sv
`timescale 1ns/1ps
module tb_gf4_dual_serial_mul;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [3:0] a_in;
  logic       b_bit;
  logic       p_bit;
  logic       p_valid;
  logic       done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gf4_dual_serial_mul dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in),
    .b_bit(b_bit), .p_bit(p_bit), .p_valid(p_valid), .done(done)
  );

  // Reference product: carry-less multiply, then reduce by x^4 + x + 1.
  function automatic logic [3:0] ref_mul(input logic [3:0] x, input logic [3:0] y);
    logic [7:0] acc;
    acc = '0;
    for (int i = 0; i < 4; i++) if (y[i]) acc ^= (8'(x) << i);
    for (int k = 7; k >= 4; k--) if (acc[k]) acc ^= (8'b0001_0011 << (k - 4));
    return acc[3:0];
  endfunction

  // d_k(x) = constant coefficient of alpha^(15-k) * x
  function automatic logic [3:0] dual_of(input logic [3:0] x);
    logic [3:0] r;
    logic [3:0] t;
    for (int k = 0; k < 4; k++) begin
      t = x;
      for (int s = 0; s < 15 - k; s++) t = ref_mul(t, 4'b0010);
      r[k] = t[0];
    end
    return r;
  endfunction

  function automatic logic [3:0] from_dual(input logic [3:0] d);
    logic [3:0] r;
    r = '0;
    for (int y = 0; y < 16; y++) if (dual_of(4'(y)) == d) r = 4'(y);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One full operation; returns the emitted dual coordinates.
  task automatic run_op(input logic [3:0] a, input logic [3:0] b,
                        input bit scramble, output logic [3:0] got);
    logic [3:0] d;
    d = dual_of(b);
    got = '0;
    @(negedge clk);
    start = 1'b1; a_in = a; b_bit = 1'b0;
    for (int j = 0; j < 7; j++) begin
      @(negedge clk);
      start = 1'b0;
      if (scramble) a_in = ~a ^ 4'(j);
      if (j < 4) b_bit = d[3 - j];
      else b_bit = scramble ? ~b_bit : 1'b0;
      #1;
      check(p_valid == (j >= 3), "R3 valid window", p_valid, (j >= 3));
      check(done == (j == 6), "R5 done position", done, (j == 6));
      if (j >= 3) got[6 - j] = p_bit;
    end
    @(negedge clk);
    b_bit = 1'b1;
    #1;
    check(!p_valid && !p_bit && !done, "R6 quiet after done",
          {p_valid, p_bit, done}, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0; a_in = 4'hF; b_bit = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(!p_valid && !p_bit && !done, "R8 in reset", {p_valid, p_bit, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(!p_valid && !p_bit && !done, "R8 after reset", {p_valid, p_bit, done}, 0);
  endtask

  task automatic t_idle_inputs;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      b_bit = j[0]; a_in = 4'(j * 3);
      #1;
      check(!p_valid && !p_bit && !done, "R6 idle input ignored",
            {p_valid, p_bit, done}, 0);
    end
  endtask

  task automatic t_all_pairs;
    logic [3:0] got;
    logic [3:0] exp;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run_op(4'(a), 4'(b), b[0], got);
        exp = ref_mul(4'(a), 4'(b));
        // R4 product value; R2 operand order; R1 when a_in was scrambled
        check(from_dual(got) == exp, "R4 product", from_dual(got), exp);
      end
    end
  endtask

  task automatic t_restart;
    logic [3:0] got;
    logic [3:0] d;
    d = dual_of(4'h9);
    @(negedge clk);
    start = 1'b1; a_in = 4'h7;
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      start = 1'b0; b_bit = d[3 - j];
    end
    run_op(4'hB, 4'h6, 1'b0, got);
    check(from_dual(got) == ref_mul(4'hB, 4'h6), "R7 restart product",
          from_dual(got), ref_mul(4'hB, 4'h6));
  endtask

  task automatic t_hold_operand;
    logic [3:0] got;
    // a3 set: first product bit equals the live last operand bit
    run_op(4'h8, 4'h1, 1'b1, got);
    check(got == dual_of(ref_mul(4'h8, 4'h1)), "R1 operand held",
          got, dual_of(ref_mul(4'h8, 4'h1)));
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_inputs();
    t_all_pairs();
    t_restart();
    t_hold_operand();
    t_idle_inputs();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule